// File: doc/BRIEF.md
# Linked-List Descriptor Loader

This block is the link stage of a single DMA channel. Software programs six channel registers through a small write port: two transfer control words, a block register whose low 16 bits hold the byte count, a source address, a destination address and a link word. When the channel's data transfer finishes, the `xfer_done` pulse asks the block to decide what happens next.

If the link word is entirely empty, the list has ended and `done_o` pulses. Otherwise the link word supplies a 32-bit-aligned, 16-bit address offset. The block joins it with the `link_base` upper address bits and reads one word from memory for each register whose reload flag is set. It reloads those registers, leaves the rest alone and pulses `next_o`. When the block register is not reloaded, its count field goes back to the last value software wrote, so the same block size repeats. A read error stops the fetch and pulses `err_o`.

Top module: `dma_link_loader`

## Requirements
- R1: After reset all six channel registers read zero and `mem_req`, `busy_o`, `done_o`, `next_o` and `err_o` are low.
- R2: A `cfg_we` write with `cfg_sel` 0..5 stores `cfg_wdata` into transfer-1, transfer-2, block, source, destination or link respectively. A link write keeps only bits [21:2] and forces the other bits to zero, so the pointer is always word aligned.
- R3: If the link word is all zero when `xfer_done` arrives, `done_o` pulses in the next cycle, no memory read is issued, and no register changes.
- R4: The first descriptor read goes to address {`link_base`, link[15:2], 2'b00}. Each later read in the same fetch goes to the previous address plus 4.
- R5: Link bits 16..21 are the reload flags for transfer-1, transfer-2, block, source, destination and link. Only flagged registers are read, one word each, in that fixed order. Registers whose flag is clear keep their values.
- R6: When the list continues and the block flag (bit 18) is clear, the block register's bits [15:0] are restored to the count most recently written by software. Its upper bits are kept.
- R7: When the link flag (bit 21) is clear, the link word is unchanged, so the next `xfer_done` fetches from the same descriptor address.
- R8: `next_o` pulses one cycle after the last descriptor word is accepted. If no flag is set and the address is nonzero, it pulses one cycle after `xfer_done` instead. It never coincides with `done_o`.
- R9: A response with `mem_rerr` high ends the fetch. `err_o` pulses in the next cycle, no further reads are issued and `next_o` does not pulse. Registers loaded earlier in that fetch keep their new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe; writes that arrive while a fetch is running are dropped |
| cfg_sel | input | 3 | Register select, 0..5 |
| cfg_wdata | input | DATA_W | Write data |
| link_base | input | ADDR_W-16 | Upper address bits of the descriptor area |
| xfer_done | input | 1 | One-cycle pulse: the data transfer has finished |
| mem_req | output | 1 | Read request, held until a response arrives |
| mem_addr | output | ADDR_W | Read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DATA_W | Read data |
| mem_rerr | input | 1 | Error flag qualifying `mem_rvalid` |
| reg_tr1 | output | DATA_W | Transfer-1 register |
| reg_tr2 | output | DATA_W | Transfer-2 register |
| reg_br | output | DATA_W | Block register (count in [15:0]) |
| reg_sar | output | DATA_W | Source address register |
| reg_dar | output | DATA_W | Destination address register |
| reg_llr | output | DATA_W | Link register |
| busy_o | output | 1 | A descriptor fetch is in progress |
| done_o | output | 1 | One-cycle pulse: the list has ended |
| next_o | output | 1 | One-cycle pulse: the next transfer may start |
| err_o | output | 1 | One-cycle pulse: the fetch was aborted by a read error |

## Verification
The main function is driven with link words whose flag patterns are a single bit, two bits that are not adjacent, all six bits, none with a nonzero address, and an alternating mix. These cases tell apart the fetch order, the count of words read, address stepping across gaps in the mask, and the flag-free continuation path. A chained pair of descriptors shows the block count being restored, and shows the link word persisting when it is not reloaded. Separate runs cover the all-zero end of list and an error on the second of three reads, which leaves the first load in place.

// File: rtl/dma_link_pkg.sv
package dma_link_pkg;
   localparam int NREG     = 6;
   localparam int FLAG_LSB = 16;
   localparam logic [31:0] LNK_KEEP = 32'h003F_FFFC;

   typedef enum logic [2:0] {
      SEL_TR1 = 3'd0,
      SEL_TR2 = 3'd1,
      SEL_BLK = 3'd2,
      SEL_SRC = 3'd3,
      SEL_DST = 3'd4,
      SEL_LNK = 3'd5
   } reg_sel_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_FETCH = 1'b1
   } seq_st_e;
endpackage

// File: rtl/dma_link_pick.sv
module dma_link_pick #(
   parameter int N  = 6,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  mask,
   output logic          any,
   output logic [IW-1:0] idx
);
   // lowest set bit wins: fixed descriptor order
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/dma_link_regs.sv
module dma_link_regs
   import dma_link_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sw_we,
   input  logic [2:0]                  sw_sel,
   input  logic [DATA_W-1:0]           sw_data,
   input  logic                        ld_we,
   input  logic [2:0]                  ld_sel,
   input  logic [DATA_W-1:0]           ld_data,
   input  logic                        restore,
   output logic [NREG-1:0][DATA_W-1:0] regs_o
);
   logic [CNT_W-1:0] shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shadow_q <= '0;
      else if (sw_we && sw_sel == SEL_BLK)
         shadow_q <= sw_data[CNT_W-1:0];
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] keep;

      if (g == int'(SEL_LNK)) begin : g_lnk
         assign keep = LNK_KEEP[DATA_W-1:0];
      end else begin : g_std
         assign keep = '1;
      end

      if (g == int'(SEL_BLK)) begin : g_blk
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (sw_we && sw_sel == 3'(g))
               q <= sw_data & keep;
            else if (ld_we && ld_sel == 3'(g))
               q <= ld_data & keep;
            else if (restore)
               q[CNT_W-1:0] <= shadow_q;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (sw_we && sw_sel == 3'(g))
               q <= sw_data & keep;
            else if (ld_we && ld_sel == 3'(g))
               q <= ld_data & keep;
         end
      end

      assign regs_o[g] = q;
   end
endmodule

// File: rtl/dma_link_seq.sv
module dma_link_seq
   import dma_link_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_done,
   input  logic [NREG-1:0]   lnk_flags,
   input  logic [13:0]       lnk_addr,
   input  logic [ADDR_W-17:0] link_base,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic              mem_rerr,
   output logic              ld_we,
   output logic [2:0]        ld_sel,
   output logic              restore,
   output logic              busy_o,
   output logic              done_o,
   output logic              next_o,
   output logic              err_o
);
   seq_st_e           st_q;
   logic [NREG-1:0]   rem_q;
   logic [NREG-1:0]   rem_nx;
   logic [ADDR_W-1:0] ptr_q;
   logic              cur_any;
   logic [2:0]        cur;
   logic              is_last;
   logic              start;

   dma_link_pick #(.N(NREG)) u_pick (
      .mask (rem_q),
      .any  (cur_any),
      .idx  (cur)
   );

   assign is_last = (lnk_flags == '0) && (lnk_addr == '0);
   assign start   = (st_q == ST_IDLE) && xfer_done;
   assign restore = start && !is_last && !lnk_flags[SEL_BLK];
   assign rem_nx  = rem_q & ~(NREG'(1) << cur);

   assign busy_o   = (st_q == ST_FETCH);
   assign mem_req  = (st_q == ST_FETCH);
   assign mem_addr = ptr_q;
   assign ld_we    = (st_q == ST_FETCH) && mem_rvalid && !mem_rerr && cur_any;
   assign ld_sel   = cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rem_q  <= '0;
         ptr_q  <= '0;
         done_o <= 1'b0;
         next_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         next_o <= 1'b0;
         err_o  <= 1'b0;
         if (st_q == ST_IDLE) begin
            if (xfer_done) begin
               if (is_last) begin
                  done_o <= 1'b1;
               end else begin
                  rem_q <= lnk_flags;
                  ptr_q <= {link_base, lnk_addr, 2'b00};
                  if (lnk_flags == '0)
                     next_o <= 1'b1;
                  else
                     st_q <= ST_FETCH;
               end
            end
         end else if (mem_rvalid) begin
            if (mem_rerr) begin
               err_o <= 1'b1;
               st_q  <= ST_IDLE;
            end else begin
               rem_q <= rem_nx;
               ptr_q <= ptr_q + ADDR_W'(4);
               if (rem_nx == '0) begin
                  st_q   <= ST_IDLE;
                  next_o <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/dma_link_loader.sv
module dma_link_loader
   import dma_link_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [ADDR_W-17:0] link_base,
   input  logic              xfer_done,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rerr,
   output logic [DATA_W-1:0] reg_tr1,
   output logic [DATA_W-1:0] reg_tr2,
   output logic [DATA_W-1:0] reg_br,
   output logic [DATA_W-1:0] reg_sar,
   output logic [DATA_W-1:0] reg_dar,
   output logic [DATA_W-1:0] reg_llr,
   output logic              busy_o,
   output logic              done_o,
   output logic              next_o,
   output logic              err_o
);
   if (DATA_W != 32) begin : g_bad_data
      $error("dma_link_loader: DATA_W must be 32");
   end
   if (ADDR_W < 17) begin : g_bad_addr
      $error("dma_link_loader: ADDR_W must exceed 16");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("dma_link_loader: CNT_W must be 1..16");
   end

   logic [NREG-1:0][DATA_W-1:0] regs;
   logic       ld_we;
   logic [2:0] ld_sel;
   logic       restore;

   dma_link_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_we   (cfg_we && !busy_o),
      .sw_sel  (cfg_sel),
      .sw_data (cfg_wdata),
      .ld_we   (ld_we),
      .ld_sel  (ld_sel),
      .ld_data (mem_rdata),
      .restore (restore),
      .regs_o  (regs)
   );

   dma_link_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_done  (xfer_done),
      .lnk_flags  (regs[SEL_LNK][FLAG_LSB +: NREG]),
      .lnk_addr   (regs[SEL_LNK][15:2]),
      .link_base  (link_base),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rerr   (mem_rerr),
      .ld_we      (ld_we),
      .ld_sel     (ld_sel),
      .restore    (restore),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .next_o     (next_o),
      .err_o      (err_o)
   );

   assign reg_tr1 = regs[SEL_TR1];
   assign reg_tr2 = regs[SEL_TR2];
   assign reg_br  = regs[SEL_BLK];
   assign reg_sar = regs[SEL_SRC];
   assign reg_dar = regs[SEL_DST];
   assign reg_llr = regs[SEL_LNK];
endmodule

// File: rtl/dma_link_loader_chk.sv
module dma_link_loader_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xfer_done,
   input logic              busy_o,
   input logic [DATA_W-1:0] reg_llr,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rvalid,
   input logic              mem_rerr,
   input logic              done_o,
   input logic              next_o,
   input logic              err_o
);
   assert_list_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && xfer_done && reg_llr == '0) |=> (done_o && !mem_req));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_rvalid && !mem_rerr) |=>
         (!mem_req || mem_addr == $past(mem_addr) + ADDR_W'(4)));

   assert_next_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      next_o |-> $past(xfer_done || (mem_rvalid && !mem_rerr)));

   assert_no_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && next_o));

   assert_err_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_rvalid && mem_rerr) |=> (err_o && !mem_req && !next_o));
endmodule

bind dma_link_loader dma_link_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xfer_done  (xfer_done),
   .busy_o     (busy_o),
   .reg_llr    (reg_llr),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rvalid (mem_rvalid),
   .mem_rerr   (mem_rerr),
   .done_o     (done_o),
   .next_o     (next_o),
   .err_o      (err_o)
);

// File: tb/dma_link_loader_tb.sv
module dma_link_loader_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [15:0] link_base = 16'h1234;
   logic        xfer_done = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_rerr = 1'b0;
   logic [31:0] reg_tr1, reg_tr2, reg_br, reg_sar, reg_dar, reg_llr;
   logic        busy_o, done_o, next_o, err_o;

   always #4 clk = ~clk;   // 125 MHz

   dma_link_loader u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .link_base(link_base), .xfer_done(xfer_done),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
      .reg_tr1(reg_tr1), .reg_tr2(reg_tr2), .reg_br(reg_br),
      .reg_sar(reg_sar), .reg_dar(reg_dar), .reg_llr(reg_llr),
      .busy_o(busy_o), .done_o(done_o), .next_o(next_o), .err_o(err_o)
   );

   // {flags[5:0], word offset[13:0]}
   localparam logic [19:0] VEC [6] = '{
      {6'b000001, 14'h010},
      {6'b100100, 14'h018},
      {6'b011010, 14'h024},
      {6'b111111, 14'h030},
      {6'b000000, 14'h040},
      {6'b010101, 14'h048}
   };

   logic [31:0] mem [256];
   logic [31:0] rd_log [16];
   logic [31:0] err_addr = 32'hFFFF_FFFF;
   int nrd = 0;
   int total = 0, bad = 0;
   int n_done = 0, n_next = 0, n_err = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] get_reg(input int i);
      case (i)
         0: return reg_tr1;
         1: return reg_tr2;
         2: return reg_br;
         3: return reg_sar;
         4: return reg_dar;
         default: return reg_llr;
      endcase
   endfunction

   function automatic logic [31:0] sw_val(input int i);
      if (i == 2) return 32'h5500_0123;
      return 32'h0A0B_0000 + 32'(i);
   endfunction

   task automatic sw(input int s, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 3'(s); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic kick();
      @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      repeat (3) @(negedge clk);
      while (busy_o) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // memory responder: one response per held request
   initial begin
      forever begin
         @(negedge clk);
         if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            mem_rerr   = 1'b0;
         end else if (mem_req) begin
            if (nrd < 16) rd_log[nrd] = mem_addr;
            nrd++;
            mem_rdata  = mem[mem_addr[9:2]];
            mem_rerr   = (mem_addr == err_addr);
            mem_rvalid = 1'b1;
         end
      end
   end

   // pulse monitor, sampled after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n) begin
            if (done_o) n_done++;
            if (err_o) n_err++;
            if (next_o) begin
               n_next++;
               chk(xfer_done || (mem_rvalid && !mem_rerr), "R8 next_o timing",
                   {31'b0, next_o}, 32'h1);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n0, d0, e0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int i = 0; i < 6; i++) chk(get_reg(i) == '0, "R1 reg reset", get_reg(i), '0);
      chk({mem_req, busy_o, done_o, next_o, err_o} == '0, "R1 outputs reset",
          {27'b0, mem_req, busy_o, done_o, next_o, err_o}, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table of flag patterns
      for (int v = 0; v < 6; v++) begin
         logic [5:0]  fl;
         logic [13:0] la;
         int k;
         fl = VEC[v][19:14];
         la = VEC[v][13:0];
         for (int i = 0; i < 6; i++) mem[int'(la) + i] = 32'hC000_0000 | (32'(la) << 8) | 32'(i);
         for (int i = 0; i < 5; i++) sw(i, sw_val(i));
         sw(5, {10'b0, fl, la, 2'b11});
         chk(reg_llr == {10'b0, fl, la, 2'b00}, "R2 link write masks low bits", reg_llr, {10'b0, fl, la, 2'b00});
         nrd = 0;
         n0 = n_next;
         kick();
         chk(n_next == n0 + 1, "R8 next_o pulse count", 32'(n_next), 32'(n0 + 1));
         chk(nrd == $countones(fl), "R5 words fetched", 32'(nrd), 32'($countones(fl)));
         k = 0;
         for (int i = 0; i < 6; i++) begin
            logic [31:0] exp;
            if (fl[i]) begin
               exp = mem[int'(la) + k];
               if (i == 5) exp = exp & 32'h003F_FFFC;
               chk(rd_log[k] == ({16'h1234, la, 2'b00} + 32'(4 * k)), "R4 fetch address",
                   rd_log[k], {16'h1234, la, 2'b00} + 32'(4 * k));
               k++;
            end else begin
               exp = (i == 5) ? {10'b0, fl, la, 2'b00} : sw_val(i);
            end
            chk(get_reg(i) == exp, "R5 register after fetch", get_reg(i), exp);
         end
      end

      // R3: empty link ends the list
      sw(5, 32'h0);
      sw(0, 32'h0000_7777);
      nrd = 0; n0 = n_next; d0 = n_done;
      kick();
      chk(n_done == d0 + 1, "R3 done_o pulse", 32'(n_done), 32'(d0 + 1));
      chk(nrd == 0, "R3 no memory read", 32'(nrd), 0);
      chk(n_next == n0, "R3 no next_o", 32'(n_next), 32'(n0));
      chk(reg_tr1 == 32'h0000_7777, "R3 registers untouched", reg_tr1, 32'h0000_7777);

      // R6 / R7: chained descriptors
      sw(0, 32'h0);
      sw(2, 32'h0000_0040);
      mem[8'h60] = 32'h7700_0999;
      mem[8'h61] = 32'h0001_01C0;   // tr1 flag only, offset 0x70
      mem[8'h70] = 32'hBEEF_0001;
      sw(5, 32'h0024_0180);         // block+link flags, offset 0x60
      kick();
      chk(reg_br == 32'h7700_0999, "R5 block loaded", reg_br, 32'h7700_0999);
      chk(reg_llr == 32'h0001_01C0, "R5 link loaded", reg_llr, 32'h0001_01C0);
      kick();
      chk(reg_br == 32'h7700_0040, "R6 block count restored", reg_br, 32'h7700_0040);
      chk(reg_tr1 == 32'hBEEF_0001, "R5 second descriptor", reg_tr1, 32'hBEEF_0001);
      chk(reg_llr == 32'h0001_01C0, "R7 link kept", reg_llr, 32'h0001_01C0);
      mem[8'h70] = 32'hCAFE_0002;
      nrd = 0;
      kick();
      chk(rd_log[0] == 32'h1234_01C0, "R7 same descriptor refetched", rd_log[0], 32'h1234_01C0);
      chk(reg_tr1 == 32'hCAFE_0002, "R7 reload from same address", reg_tr1, 32'hCAFE_0002);

      // R9: error on second of three reads
      sw(0, 32'h1); sw(1, 32'h2); sw(2, 32'h33);
      mem[8'h80] = 32'hAAAA_0001;
      mem[8'h81] = 32'hAAAA_0002;
      mem[8'h82] = 32'hAAAA_0003;
      err_addr = 32'h1234_0204;
      sw(5, 32'h0007_0200);
      nrd = 0; n0 = n_next; e0 = n_err;
      kick();
      chk(n_err == e0 + 1, "R9 err_o pulse", 32'(n_err), 32'(e0 + 1));
      chk(n_next == n0, "R9 no next_o", 32'(n_next), 32'(n0));
      chk(nrd == 2, "R9 fetch stopped", 32'(nrd), 2);
      chk(reg_tr1 == 32'hAAAA_0001, "R9 earlier load kept", reg_tr1, 32'hAAAA_0001);
      chk(reg_tr2 == 32'h2, "R9 failed word not loaded", reg_tr2, 32'h2);
      chk(reg_br == 32'h33, "R9 later word not loaded", reg_br, 32'h33);
      err_addr = 32'hFFFF_FFFF;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule